// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a narrow 12-bit port and a wide 24-bit port that is split into a first half and a second half. Going narrow to wide, two narrow words presented on consecutive cycles come out together as one wide word. The first half passes through a two-register pipeline and the second half through a single register, so the older word lands in the first half and the newer word in the second half on the same edge.

Going wide to narrow, each half of the wide input is captured into its own register. A registered half-select then chooses which stored half drives the narrow output. Every storage element has its own active-low load enable. Both output enables are active low and registered, so each port turns on or off only at a clock edge.

Each would-be three-state port is modelled as a data-out bus plus a drive flag. The data-out bus reads zero whenever its port is not driving. A synchronous active-low reset clears every data register, clears the registered select to the second half and turns both ports off.

Top module: `xchg_bus_exchanger`

## Requirements
- R1: When `rst_n` is low at a rising edge, every data register clears and both drive flags go to 0. After that edge, `nar_out`, `wf_out` and `ws_out` read 0 and `nar_drv` and `wid_drv` read 0. The data registers still hold 0 after the ports are enabled again.
- R2: Each storage element changes only at a rising edge and only when its own active-low enable is 0. Otherwise it keeps its value, whatever happens on its data input.
- R3: A word on `nar_in` reaches `wf_out` after two rising edges at which `pack_f_n` is 0. Those two edges need not be consecutive. One enabled edge is not enough.
- R4: A word on `nar_in` reaches `ws_out` after one rising edge with `pack_s_n` at 0. This path does not depend on `pack_f_n`.
- R5: Present word 1 with `pack_f_n`=0, then on the next cycle present word 2 with `pack_f_n`=0 and `pack_s_n`=0. After that edge, `wf_out` shows word 1 and `ws_out` shows word 2 together.
- R6: `wf_in` is captured under `unpk_f_n`=0 and `ws_in` under `unpk_s_n`=0. Each capture is independent of the other.
- R7: `pick_first` is sampled at the rising edge. A sampled 1 drives the stored first half onto `nar_out`, and a sampled 0 drives the stored second half. A change of `pick_first` between edges has no effect on `nar_out`.
- R8: `nar_drv` equals the inverse of `nar_oe_n` as sampled at the previous edge, and `wid_drv` does the same for `wid_oe_n`. The two enables act independently, so all four on/off combinations are reachable.
- R9: While `nar_drv` is 0, `nar_out` is 0. While `wid_drv` is 0, `wf_out` and `ws_out` are 0.
- R10: `nar_out` keeps its level while the selected capture register and the sampled select are unchanged. This holds even when the unselected register is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| nar_in | input | 12 | Narrow port input word |
| nar_out | output | 12 | Narrow port output word (0 when not driving) |
| nar_drv | output | 1 | Narrow port drive flag |
| wf_in | input | 12 | Wide port first-half input |
| ws_in | input | 12 | Wide port second-half input |
| wf_out | output | 12 | Wide port first-half output (0 when not driving) |
| ws_out | output | 12 | Wide port second-half output (0 when not driving) |
| wid_drv | output | 1 | Wide port drive flag |
| pack_f_n | input | 1 | Active-low load enable of the two-stage first-half pipeline |
| pack_s_n | input | 1 | Active-low load enable of the second-half register |
| unpk_f_n | input | 1 | Active-low capture enable for `wf_in` |
| unpk_s_n | input | 1 | Active-low capture enable for `ws_in` |
| pick_first | input | 1 | Half-select, registered: 1 = first half, 0 = second half |
| nar_oe_n | input | 1 | Active-low narrow output enable, registered |
| wid_oe_n | input | 1 | Active-low wide output enable, registered |

## Verification
The bench checks the first-half path after a single enabled edge, where it must still show the old value. It then checks it across a gap in `pack_f_n`. A design with one stage, or with the stages advancing on every edge, would put the word out early or lose it. The half-select and the output enables are toggled between edges and read back before the next edge. A combinational select or enable would switch at once instead of one edge later. The bench loads the unselected half, walks all four enable combinations while checking that disabled buses read zero, and runs a reset after traffic to catch registers that survive it.

// File: rtl/xchg_pkg.sv
// Package: shared types of the bus exchanger.
// Assumes: nothing beyond IEEE 1800-2017.
package xchg_pkg;

    // Which stored wide half drives the narrow port.
    typedef enum logic {
        HALF_SECOND = 1'b0,
        HALF_FIRST  = 1'b1
    } half_e;

endpackage

// File: rtl/xchg_hold_reg.sv
// Module: one word register with an active-low load enable.
// Assumes: synchronous active-low reset; holds its value when load_n is high.
module xchg_hold_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d on an enabled edge, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!load_n) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xchg_gather.sv
// Module: narrow-to-wide path. The first half runs through a STAGES-deep
// pipeline under one enable, and the second half through one register.
// Assumes: STAGES >= 1; all stages advance together on an enabled edge.
module xchg_gather #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nar_in,
    input  logic         pack_f_n,
    input  logic         pack_s_n,
    output logic [W-1:0] first_q,
    output logic [W-1:0] second_q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the first-half pipeline on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (!pack_f_n) begin
            stage_q[0] <= nar_in;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign first_q = stage_q[LAST];

    xchg_hold_reg #(.W(W)) u_second (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (pack_s_n),
        .d      (nar_in),
        .q      (second_q)
    );

endmodule

// File: rtl/xchg_split.sv
// Module: wide-to-narrow path. Each half is captured into its own register,
// and a registered select picks the stored half.
// Assumes: the select is sampled on every edge, with no enable.
module xchg_split #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wf_in,
    input  logic [W-1:0] ws_in,
    input  logic         unpk_f_n,
    input  logic         unpk_s_n,
    input  logic         pick_first,
    output logic [W-1:0] picked
);

    import xchg_pkg::*;

    localparam int unsigned HALVES = 2;

    logic [HALVES-1:0][W-1:0] half_d;
    logic [HALVES-1:0][W-1:0] half_q;
    logic [HALVES-1:0]        half_ld_n;
    half_e                    pick_q;

    assign half_d    = {ws_in, wf_in};
    assign half_ld_n = {unpk_s_n, unpk_f_n};

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        xchg_hold_reg #(.W(W)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (half_ld_n[g]),
            .d      (half_d[g]),
            .q      (half_q[g])
        );
    end

    // Sample the half-select on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q <= HALF_SECOND;
        end else begin
            pick_q <= half_e'(pick_first);
        end
    end

    // Route the selected stored half.
    always_comb begin
        picked = (pick_q == HALF_FIRST) ? half_q[0] : half_q[1];
    end

endmodule

// File: rtl/xchg_port_drive.sv
// Module: registered active-low output enable plus zero gating of a port.
// Assumes: drive is off after reset; the data bus reads 0 while off.
module xchg_port_drive #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic [W-1:0] word,
    output logic         drv,
    output logic [W-1:0] bus
);

    // Register the enable so the port switches only at edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv <= 1'b0;
        end else begin
            drv <= !oe_n;
        end
    end

    // Force the bus to zero while the port is off.
    always_comb begin
        bus = drv ? word : '0;
    end

endmodule

// File: rtl/xchg_bus_exchanger.sv
// Module: top of the narrow/wide registered bus exchanger.
// Assumes: a single clock; three-state ports are modelled as bus plus drive flag.
module xchg_bus_exchanger #(
    parameter int unsigned NARROW_W     = 12,
    parameter int unsigned FIRST_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NARROW_W-1:0] nar_in,
    output logic [NARROW_W-1:0] nar_out,
    output logic                nar_drv,
    input  logic [NARROW_W-1:0] wf_in,
    input  logic [NARROW_W-1:0] ws_in,
    output logic [NARROW_W-1:0] wf_out,
    output logic [NARROW_W-1:0] ws_out,
    output logic                wid_drv,
    input  logic                pack_f_n,
    input  logic                pack_s_n,
    input  logic                unpk_f_n,
    input  logic                unpk_s_n,
    input  logic                pick_first,
    input  logic                nar_oe_n,
    input  logic                wid_oe_n
);

    localparam int unsigned WIDE_W = 2 * NARROW_W;

    logic [NARROW_W-1:0] first_q;
    logic [NARROW_W-1:0] second_q;
    logic [NARROW_W-1:0] picked;
    logic [WIDE_W-1:0]   wide_bus;

    xchg_gather #(.W(NARROW_W), .STAGES(FIRST_STAGES)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .nar_in   (nar_in),
        .pack_f_n (pack_f_n),
        .pack_s_n (pack_s_n),
        .first_q  (first_q),
        .second_q (second_q)
    );

    xchg_split #(.W(NARROW_W)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .wf_in      (wf_in),
        .ws_in      (ws_in),
        .unpk_f_n   (unpk_f_n),
        .unpk_s_n   (unpk_s_n),
        .pick_first (pick_first),
        .picked     (picked)
    );

    xchg_port_drive #(.W(NARROW_W)) u_nar_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .oe_n  (nar_oe_n),
        .word  (picked),
        .drv   (nar_drv),
        .bus   (nar_out)
    );

    xchg_port_drive #(.W(WIDE_W)) u_wid_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .oe_n  (wid_oe_n),
        .word  ({second_q, first_q}),
        .drv   (wid_drv),
        .bus   (wide_bus)
    );

    assign wf_out = wide_bus[NARROW_W-1:0];
    assign ws_out = wide_bus[WIDE_W-1:NARROW_W];

endmodule

// File: rtl/xchg_bus_exchanger_chk.sv
// Module: protocol checker for the exchanger, attached by bind below.
// Assumes: the default two-stage first-half pipeline for the R3 property.
module xchg_bus_exchanger_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] nar_in,
    input logic [W-1:0] nar_out,
    input logic         nar_drv,
    input logic [W-1:0] wf_in,
    input logic [W-1:0] ws_in,
    input logic [W-1:0] wf_out,
    input logic [W-1:0] ws_out,
    input logic         wid_drv,
    input logic         pack_f_n,
    input logic         pack_s_n,
    input logic         unpk_f_n,
    input logic         unpk_s_n,
    input logic         pick_first,
    input logic         nar_oe_n,
    input logic         wid_oe_n
);

    logic was_rst_q = 1'b0;

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (!nar_drv && !wid_drv && nar_out == '0 && wf_out == '0 && ws_out == '0));

    p_first_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_f_n && !wid_oe_n && wid_drv) |=> (wf_out == $past(wf_out)));

    p_first_two_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pack_f_n && !$past(pack_f_n) && $past(rst_n) && !wid_oe_n) |=> (wf_out == $past(nar_in, 2)));

    p_second_one_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pack_s_n && !wid_oe_n) |=> (ws_out == $past(nar_in)));

    p_pick_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!unpk_f_n && pick_first && !nar_oe_n) |=> (nar_out == $past(wf_in)));

    p_pick_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!unpk_s_n && !pick_first && !nar_oe_n) |=> (nar_out == $past(ws_in)));

    p_nar_enable_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (nar_drv == !$past(nar_oe_n)));

    p_wid_enable_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wid_drv == !$past(wid_oe_n)));

    p_nar_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nar_drv |-> (nar_out == '0));

    p_wid_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wid_drv |-> (wf_out == '0 && ws_out == '0));

endmodule

bind xchg_bus_exchanger xchg_bus_exchanger_chk #(.W(NARROW_W)) u_chk (.*);

// File: tb/xchg_bus_exchanger_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checked at the falling edge.
module xchg_bus_exchanger_test;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] nar_in, wf_in, ws_in;
    logic [W-1:0] nar_out, wf_out, ws_out;
    logic         nar_drv, wid_drv;
    logic         pack_f_n, pack_s_n, unpk_f_n, unpk_s_n, pick_first;
    logic         nar_oe_n, wid_oe_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xchg_bus_exchanger uut (
        .clk(clk), .rst_n(rst_n),
        .nar_in(nar_in), .nar_out(nar_out), .nar_drv(nar_drv),
        .wf_in(wf_in), .ws_in(ws_in), .wf_out(wf_out), .ws_out(ws_out),
        .wid_drv(wid_drv),
        .pack_f_n(pack_f_n), .pack_s_n(pack_s_n),
        .unpk_f_n(unpk_f_n), .unpk_s_n(unpk_s_n),
        .pick_first(pick_first), .nar_oe_n(nar_oe_n), .wid_oe_n(wid_oe_n)
    );

    // Compare one value and log a failure line.
    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one cycle: capture at the rising edge, return at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // All load enables off, select on the second half.
    task automatic idle();
        pack_f_n = 1'b1; pack_s_n = 1'b1;
        unpk_f_n = 1'b1; unpk_s_n = 1'b1;
        pick_first = 1'b0;
    endtask

    // R1: reset with loads and enables requested still turns everything off.
    task automatic t_reset();
        rst_n = 1'b0; nar_oe_n = 1'b0; wid_oe_n = 1'b0;
        pack_f_n = 1'b0; pack_s_n = 1'b0; unpk_f_n = 1'b0; unpk_s_n = 1'b0;
        nar_in = 12'hABC; wf_in = 12'h123; ws_in = 12'h456;
        step();
        chk("R1 nar_drv", nar_drv, 0);
        chk("R1 wid_drv", wid_drv, 0);
        chk("R1 nar_out", nar_out, 0);
        chk("R1 wf_out", wf_out, 0);
        chk("R1 ws_out", ws_out, 0);
        idle();
        rst_n = 1'b1; nar_oe_n = 1'b1; wid_oe_n = 1'b1;
        step();
    endtask

    // R3 R4 R5: pack two narrow words into one wide word.
    task automatic t_pack();
        wid_oe_n = 1'b0;
        nar_in = 12'h111; pack_f_n = 1'b0; pack_s_n = 1'b1;
        step();
        chk("R3 one edge not enough", wf_out, 0);
        chk("R4 second untouched", ws_out, 0);
        nar_in = 12'h222; pack_f_n = 1'b0; pack_s_n = 1'b0;
        step();
        chk("R5 first half word1", wf_out, 12'h111);
        chk("R5 second half word2", ws_out, 12'h222);
    endtask

    // R2: disabled loads ignore the data input.
    task automatic t_hold();
        idle();
        nar_in = 12'hFFF;
        step();
        step();
        chk("R2 first held", wf_out, 12'h111);
        chk("R2 second held", ws_out, 12'h222);
    endtask

    // R3 R4: the first-half pipeline across a gap; the second half on its own.
    task automatic t_gap();
        nar_in = 12'h333; pack_f_n = 1'b0;
        step();
        chk("R3 stage advance", wf_out, 12'h222);
        nar_in = 12'hEEE; pack_f_n = 1'b1;
        step();
        chk("R2 gap hold", wf_out, 12'h222);
        nar_in = 12'hDDD; pack_f_n = 1'b0;
        step();
        chk("R3 after second enabled edge", wf_out, 12'h333);
        chk("R4 second unaffected by first enable", ws_out, 12'h222);
        nar_in = 12'h444; pack_f_n = 1'b1; pack_s_n = 1'b0;
        step();
        chk("R4 one edge", ws_out, 12'h444);
        chk("R2 first held while second loads", wf_out, 12'h333);
        idle();
    endtask

    // R6 R7 R10: capture the wide halves and select them onto the narrow port.
    task automatic t_split();
        nar_oe_n = 1'b0;
        wf_in = 12'hA01; ws_in = 12'hB02;
        unpk_f_n = 1'b0; unpk_s_n = 1'b0; pick_first = 1'b1;
        step();
        chk("R7 pick first", nar_out, 12'hA01);
        unpk_f_n = 1'b1; unpk_s_n = 1'b1;
        wf_in = 12'h0F0; ws_in = 12'h00F; pick_first = 1'b0;
        #1;
        chk("R7 select registered", nar_out, 12'hA01);
        step();
        chk("R6 second held and picked", nar_out, 12'hB02);
        step();
        chk("R10 steady", nar_out, 12'hB02);
        unpk_f_n = 1'b0; wf_in = 12'hA03;
        step();
        chk("R10 unselected load", nar_out, 12'hB02);
        unpk_f_n = 1'b1; pick_first = 1'b1;
        step();
        chk("R6 first captured alone", nar_out, 12'hA03);
    endtask

    // R8 R9: all four enable combinations, registered.
    task automatic t_oe();
        nar_oe_n = 1'b1; wid_oe_n = 1'b1;
        #1;
        chk("R8 nar not yet off", nar_drv, 1);
        chk("R8 wid not yet off", wid_drv, 1);
        step();
        chk("R8 both off nar", nar_drv, 0);
        chk("R8 both off wid", wid_drv, 0);
        chk("R9 nar zero", nar_out, 0);
        chk("R9 wf zero", wf_out, 0);
        chk("R9 ws zero", ws_out, 0);
        nar_oe_n = 1'b0;
        step();
        chk("R8 nar only", {nar_drv, wid_drv}, 2'b10);
        chk("R9 wide zero", ws_out, 0);
        chk("R8 nar data", nar_out, 12'hA03);
        nar_oe_n = 1'b1; wid_oe_n = 1'b0;
        step();
        chk("R8 wid only", {nar_drv, wid_drv}, 2'b01);
        chk("R9 nar zero again", nar_out, 0);
        chk("R8 wid data", ws_out, 12'h444);
        nar_oe_n = 1'b0;
        step();
        chk("R8 both on", {nar_drv, wid_drv}, 2'b11);
        chk("R8 both on first", wf_out, 12'h333);
    endtask

    // R1: reset after traffic clears the stored data.
    task automatic t_reset_clears();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 ports back on", {nar_drv, wid_drv}, 2'b11);
        chk("R1 nar cleared", nar_out, 0);
        chk("R1 wf cleared", wf_out, 0);
        chk("R1 ws cleared", ws_out, 0);
    endtask

    initial begin
        idle();
        rst_n = 1'b0; nar_oe_n = 1'b1; wid_oe_n = 1'b1;
        nar_in = '0; wf_in = '0; ws_in = '0;
        @(negedge clk);
        t_reset();
        t_pack();
        t_hold();
        t_gap();
        t_split();
        t_oe();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule